// File: doc/BRIEF.md
# Gated Port Input Buffer Controller

This block is the input side of a small group of general-purpose ports. Every port pin passes through a two-flop synchronizer. The synchronized level then feeds two places. The first is a direct pin-status read path that software can always read. The second is a gated path toward on-chip peripherals. For each pin, a buffer-enable bit selects one of two behaviours on the gated path: it carries the synchronized level, or it is held at logic 1.

A per-pin edge detector watches the gated path and records the selected polarity in a sticky flag. Software clears a flag by writing 1 to it. Gating a low pin in or out switches the gated line between the pin level and the forced-high value. That switch looks like a real edge, so software must clear any flag raised by an enable change before it relies on the flag again. The number of implemented enable bits is set for each port by an 8-bit mask parameter. Bits outside the mask are reserved.

Top module: `gpio_inbuf_ctrl`

## Requirements
- R1: After synchronous reset, every enable, edge-select and flag register reads 0x00 and every bit of `periph_in` is 1.
- R2: With a pin's enable bit at 1, `periph_in` follows the pin through exactly two clock stages. A pin change driven between edges shows on `periph_in` after the second following rising edge, not after the first.
- R3: With a pin's enable bit at 0, that pin's `periph_in` bit is 1 whatever the pin level.
- R4: Reading the pin-status register (offset 1) returns the synchronized pin levels, unaffected by the enable bits.
- R5: Bits outside a port's mask (defaults: port 0 0xFF, port 1 0x3F, port 2 0x0F) read back as 0 in the enable, edge-select and flag registers, ignore writes, and keep `periph_in` at 1.
- R6: Address bits [1:0] select the register (0 enable, 1 pin status, 2 edge select, 3 flags) and the upper bits select the port. A write lands on the rising edge where `bus_wen` is sampled high. `bus_rdata` is combinational from the addressed register, so during the write cycle it still shows the old value.
- R7: An edge-select bit of 0 flags rising edges of the gated line and a bit of 1 flags falling edges. The flag is set on the edge after the gated line changes, and the other polarity sets nothing.
- R8: A flag stays set until software writes 1 to its bit at offset 3. Writing 0 leaves it set. A new edge in the same cycle as the clear takes precedence.
- R9: Setting an enable bit while the pin is low gives a falling edge on the gated line, and clearing it again gives a rising edge. Both are flagged like real pin edges and can be cleared by a 1-write.
- R10: Writes to the pin-status offset change nothing, and reads of a port index beyond the last port return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | PORT_W+2 | Register address: port index above, register offset in [1:0] |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | NUM_PORTS*8 | Raw pin levels, asynchronous, port p at bits [8p+7:8p] |
| periph_in | output | NUM_PORTS*8 | Gated pin levels toward peripherals |
| edge_flag | output | NUM_PORTS*8 | Sticky edge flags |

## Verification
The bound checker checks five things on every cycle: the reset values; that an enable write lands masked on the next edge; that reserved bits stay forced high with no flags; that a flag stays sticky unless a 1 is written to it; and that a gated-line edge of the selected polarity sets its flag one cycle later. The directed scenarios cover the rest. These are the two-stage pin latency, the pin-status read staying independent of gating, and the combinational read showing the old value during a write. They also cover the spurious edges from gating a low pin in and out, and the ignored writes and unused port addresses, which show only at the bus and pin ports.

// File: rtl/gib_pkg.sv
package gib_pkg;
  localparam int REG_W = 8;

  typedef enum logic [1:0] {
    OFS_ENABLE  = 2'd0,
    OFS_PINS    = 2'd1,
    OFS_EDGESEL = 2'd2,
    OFS_FLAGS   = 2'd3
  } gib_ofs_e;

  typedef struct packed {
    logic             hit;
    gib_ofs_e         ofs;
    logic [REG_W-1:0] data;
  } gib_wr_t;
endpackage

// File: rtl/gib_sync.sv
module gib_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gib_edge.sv
module gib_edge #(
  parameter int         W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gated,
  input  logic [W-1:0] falling_sel,
  input  logic         clr_stb,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] flags
);
  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] hit;
  logic [W-1:0] clr_mask;

  always_comb begin
    rise     = gated & ~prev_q;
    fall     = ~gated & prev_q;
    hit      = ((rise & ~falling_sel) | (fall & falling_sel)) & MASK;
    clr_mask = clr_stb ? clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '1;
      flags  <= '0;
    end else begin
      prev_q <= gated;
      flags  <= ((flags & ~clr_mask) | hit) & MASK;
    end
  end
endmodule

// File: rtl/gib_port.sv
module gib_port
  import gib_pkg::*;
#(
  parameter logic [REG_W-1:0] MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  gib_wr_t          wr,
  input  gib_ofs_e         rd_ofs,
  input  logic [REG_W-1:0] pins,
  output logic [REG_W-1:0] gated,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] sel_q,
  output logic [REG_W-1:0] flags,
  output logic [REG_W-1:0] rdata
);
  logic clr_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      sel_q <= '0;
    end else if (wr.hit) begin
      if (wr.ofs == OFS_ENABLE)  en_q  <= wr.data & MASK;
      if (wr.ofs == OFS_EDGESEL) sel_q <= wr.data & MASK;
    end
  end

  assign gated   = pins | ~en_q;
  assign clr_stb = wr.hit && (wr.ofs == OFS_FLAGS);

  gib_edge #(.W(REG_W), .MASK(MASK)) u_edge (
    .clk         (clk),
    .rst         (rst),
    .gated       (gated),
    .falling_sel (sel_q),
    .clr_stb     (clr_stb),
    .clr_bits    (wr.data),
    .flags       (flags)
  );

  always_comb begin
    unique case (rd_ofs)
      OFS_ENABLE:  rdata = en_q;
      OFS_PINS:    rdata = pins;
      OFS_EDGESEL: rdata = sel_q;
      OFS_FLAGS:   rdata = flags;
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_inbuf_ctrl.sv
module gpio_inbuf_ctrl
  import gib_pkg::*;
#(
  parameter int                       NUM_PORTS   = 3,
  parameter logic [NUM_PORTS*8-1:0]   PORT_MASKS  = 24'h0F3FFF,
  parameter int                       SYNC_STAGES = 2,
  localparam int                      PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS + 1) : 1,
  localparam int                      ADDR_W      = PORT_W + 2,
  localparam int                      PINS        = NUM_PORTS * REG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   periph_in,
  output logic [PINS-1:0]   edge_flag
);
  logic [PINS-1:0]   pins_s;
  logic [PINS-1:0]   en_all;
  logic [PINS-1:0]   sel_all;
  logic [REG_W-1:0]  port_rd [NUM_PORTS];
  logic [PORT_W-1:0] port_idx;
  gib_ofs_e          ofs;

  assign port_idx = bus_addr[ADDR_W-1:2];
  assign ofs      = gib_ofs_e'(bus_addr[1:0]);

  gib_sync #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pins_s)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_port
      gib_wr_t wr;
      assign wr.hit  = bus_wen && (port_idx == PORT_W'(p));
      assign wr.ofs  = ofs;
      assign wr.data = bus_wdata;

      gib_port #(.MASK(PORT_MASKS[p*REG_W +: REG_W])) u_port (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd_ofs (ofs),
        .pins   (pins_s[p*REG_W +: REG_W]),
        .gated  (periph_in[p*REG_W +: REG_W]),
        .en_q   (en_all[p*REG_W +: REG_W]),
        .sel_q  (sel_all[p*REG_W +: REG_W]),
        .flags  (edge_flag[p*REG_W +: REG_W]),
        .rdata  (port_rd[p])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (port_idx == PORT_W'(i)) bus_rdata = port_rd[i];
    end
  end
endmodule

// File: rtl/gib_checker.sv
module gib_checker
  import gib_pkg::*;
#(
  parameter int                     NUM_PORTS  = 3,
  parameter logic [NUM_PORTS*8-1:0] PORT_MASKS = 24'h0F3FFF,
  parameter int                     PORT_W     = 2,
  localparam int                    ADDR_W     = PORT_W + 2,
  localparam int                    PINS       = NUM_PORTS * REG_W
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [PINS-1:0]   periph_in,
  input logic [PINS-1:0]   edge_flag,
  input logic [PINS-1:0]   en_all,
  input logic [PINS-1:0]   sel_all
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (en_all == '0 && sel_all == '0 && edge_flag == '0));

  genvar p, b;
  generate
    for (p = 0; p < NUM_PORTS; p++) begin : g_p
      localparam logic [REG_W-1:0] M = PORT_MASKS[p*REG_W +: REG_W];

      // R6
      a_r6_enable_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == {PORT_W'(p), 2'(OFS_ENABLE)})
        |=> (en_all[p*REG_W +: REG_W] == ($past(bus_wdata) & M)));

      for (b = 0; b < REG_W; b++) begin : g_b
        localparam int I = p*REG_W + b;
        if (M[b]) begin : g_impl
          // R8
          a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
            (edge_flag[I] && !(bus_wen && bus_addr == {PORT_W'(p), 2'(OFS_FLAGS)} && bus_wdata[b]))
            |=> edge_flag[I]);
          // R7
          a_r7_rise_flags: assert property (@(posedge clk) disable iff (rst)
            ($rose(periph_in[I]) && !sel_all[I]) |=> edge_flag[I]);
          // R7
          a_r7_fall_flags: assert property (@(posedge clk) disable iff (rst)
            ($fell(periph_in[I]) && sel_all[I]) |=> edge_flag[I]);
        end else begin : g_rsvd
          // R5
          a_r5_reserved_high: assert property (@(posedge clk) disable iff (rst)
            1'b1 |-> (periph_in[I] && !edge_flag[I] && !en_all[I] && !sel_all[I]));
        end
      end
    end
  endgenerate
endmodule

bind gpio_inbuf_ctrl gib_checker #(
  .NUM_PORTS  (NUM_PORTS),
  .PORT_MASKS (PORT_MASKS),
  .PORT_W     (PORT_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wen   (bus_wen),
  .bus_wdata (bus_wdata),
  .periph_in (periph_in),
  .edge_flag (edge_flag),
  .en_all    (en_all),
  .sel_all   (sel_all)
);

// File: tb/tb_gpio_inbuf_ctrl.sv
module tb_gpio_inbuf_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wen = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [23:0] pins = '0;
  logic [23:0] periph_in;
  logic [23:0] edge_flag;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  gpio_inbuf_ctrl dut (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pins),
    .periph_in (periph_in),
    .edge_flag (edge_flag)
  );

  function automatic logic [3:0] ad(input int p, input int o);
    return {p[1:0], o[1:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input int o, input logic [7:0] d);
    @(negedge clk);
    bus_addr = ad(p, o); bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input int p, input int o, output logic [7:0] d);
    bus_addr = ad(p, o);
    #1;
    d = bus_rdata;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int p = 0; p < 3; p++) begin
      rd(p, 0, v); chk("R1 enable", v, 8'h00);
      rd(p, 2, v); chk("R1 edgesel", v, 8'h00);
      rd(p, 3, v); chk("R1 flags", v, 8'h00);
    end
    chk("R1 periph high", periph_in, 24'hFFFFFF);
  endtask

  task automatic t_gate;
    logic [7:0] v;
    @(negedge clk); pins[7:0] = 8'hA5;
    settle(3);
    chk("R3 disabled forced high", periph_in[7:0], 8'hFF);
    rd(0, 1, v); chk("R4 pin read while gated", v, 8'hA5);
    wr(0, 0, 8'hFF);
    chk("R2 enabled passes pin", periph_in[7:0], 8'hA5);
    wr(0, 0, 8'h0F);
    chk("R3 partial gating", periph_in[7:0], 8'hF5);
    rd(0, 1, v); chk("R4 pin read unaffected", v, 8'hA5);
    wr(0, 0, 8'hFF);
    pins[7:0] = 8'h5A;
    @(negedge clk);
    chk("R2 not after one stage", periph_in[7:0], 8'hA5);
    @(negedge clk);
    chk("R2 after two stages", periph_in[7:0], 8'h5A);
  endtask

  task automatic t_reserved;
    logic [7:0] v;
    @(negedge clk); pins[23:8] = 16'h0000;
    settle(3);
    wr(1, 0, 8'hFF);
    rd(1, 0, v); chk("R5 port1 enable readback", v, 8'h3F);
    chk("R5 port1 reserved high", periph_in[15:8], 8'hC0);
    wr(2, 0, 8'hFF);
    wr(2, 2, 8'hFF);
    rd(2, 2, v); chk("R5 port2 edgesel readback", v, 8'h0F);
    chk("R5 port2 reserved high", periph_in[23:16], 8'hF0);
    wr(1, 3, 8'hFF); wr(2, 3, 8'hFF);
  endtask

  task automatic t_write_timing;
    logic [7:0] v;
    wr(0, 2, 8'h00);
    @(negedge clk);
    bus_addr = ad(0, 2); bus_wdata = 8'h3C; bus_wen = 1'b1;
    #1; chk("R6 old value during write", bus_rdata, 8'h00);
    @(negedge clk); bus_wen = 1'b0;
    rd(0, 2, v); chk("R6 new value after edge", v, 8'h3C);
    wr(0, 2, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(0, 1, 8'h00);
    rd(0, 1, v); chk("R10 pin offset write ignored", v, 8'h5A);
    rd(3, 0, v); chk("R10 unused port reads zero", v, 8'h00);
  endtask

  task automatic t_edges;
    logic [7:0] v;
    wr(0, 0, 8'h00);
    @(negedge clk); pins[7:0] = 8'h00;
    settle(3);
    wr(0, 2, 8'hFF);
    wr(0, 3, 8'hFF);
    rd(0, 3, v); chk("R8 flags cleared", v, 8'h00);
    wr(0, 0, 8'h01);
    @(negedge clk);
    rd(0, 3, v); chk("R9 enable on low pin gives fall flag", v, 8'h01);
    wr(0, 3, 8'h00);
    rd(0, 3, v); chk("R8 write 0 keeps flag", v, 8'h01);
    wr(0, 3, 8'h01);
    @(negedge clk);
    rd(0, 3, v); chk("R8 write 1 clears flag", v, 8'h00);
    wr(0, 2, 8'h00);
    wr(0, 0, 8'h02);
    @(negedge clk);
    rd(0, 3, v); chk("R7 falling ignored when rising selected", v, 8'h01);
    wr(0, 3, 8'hFF);
    @(negedge clk); pins[1] = 1'b1;
    settle(4);
    rd(0, 3, v); chk("R7 rising pin edge flagged", v, 8'h02);
    wr(0, 3, 8'hFF);
    wr(0, 0, 8'h03);
    wr(0, 3, 8'hFF);
    @(negedge clk);
    rd(0, 3, v); chk("R9 cleared before disable", v, 8'h00);
    wr(0, 0, 8'h02);
    @(negedge clk);
    rd(0, 3, v); chk("R9 disable on low pin gives rise flag", v, 8'h01);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gate();
    t_reserved();
    t_write_timing();
    t_ignored();
    t_edges();
    report();
  end
endmodule